// File: doc/BRIEF.md
# Ping-Pong Transfer Buffer with Byte Counter

This block sits between a 16-bit host data port and a byte-wide SCSI data engine. It holds two equal word-wide FIFO banks. At any time one bank belongs to the host and the other to the engine. The host fills or drains its bank one 16-bit word at a time, with the lower byte first on the wire. The engine moves single bytes into or out of its own bank. A one-cycle flip pulse swaps the ownership of the two banks. Data written by the host can then be sent by the engine, and data received by the engine can be read by the host.

The engine side is limited by a byte budget. The host loads the budget as two bytes, an upper part and a lower part. Neither load has any effect until a separate arm pulse copies the pair into the live counter. The engine moves exactly that many bytes and then stops, and a completion flag rises. A new budget can be armed for the next chunk while the host is still reading the previous chunk out of its own bank. The `dir_in` input is decoded from the bus phase and sets the engine direction. When it is high (data-in), the engine reads bytes from its bank. When it is low (data-out), the engine writes bytes into its bank.

Top module: `pp_xfer_buf`

## Requirements
- R1: After reset both banks are empty, the host owns bank 0, `host_empty`=1, `alt_empty`=1, `host_full`=0, `done`=0, and the engine offers no byte and no room.
- R2: A host word write stores 16 bits in the host bank, and `host_rd_data` always shows the oldest stored word. A host read removes that word. `host_full` is 1 when the bank holds WORDS words, and a write while full is ignored.
- R3: In data-in (`dir_in`=1), the engine receives each stored word as two bytes, bits [7:0] first and then bits [15:8].
- R4: In data-out (`dir_in`=0), each pair of engine bytes is packed into one word with the first byte in bits [7:0]. The host reads that word after a flip.
- R5: A flip pulse swaps the two banks, so the host flags and data port then refer to the bank the engine used before.
- R6: Loading the upper and lower count bytes does not arm the engine. Only the arm pulse makes the count {upper,lower} live.
- R7: After arming, the engine moves exactly the armed number of bytes. After that, `eng_byte_valid` and `eng_room` stay 0.
- R8: `done` rises in the cycle after the last counted byte moves. It stays set until the next arm pulse, and the arm pulse clears it.
- R9: With an odd count in data-in, the upper byte of the final word is dropped, and the word leaves the engine bank.
- R10: With an odd count in data-out, the final word is stored with bits [15:8] equal to zero.
- R11: Arming a new count does not disturb the words the host is still reading from its own bank.
- R12: While armed, the engine waits when its bank is empty (data-in, `eng_byte_valid`=0) or full (data-out, `eng_room`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_in | input | 1 | 1: engine reads its bank (data-in); 0: engine writes it (data-out) |
| host_wr_en | input | 1 | Host pushes one word into its bank |
| host_wr_data | input | 16 | Word to push, first byte in bits [7:0] |
| host_rd_en | input | 1 | Host pops the oldest word of its bank |
| host_rd_data | output | 16 | Oldest word of the host bank (show-ahead) |
| cnt_hi_we | input | 1 | Load the upper count byte from `cnt_byte` |
| cnt_lo_we | input | 1 | Load the lower count byte from `cnt_byte` |
| cnt_byte | input | 8 | Count byte being loaded |
| cnt_set | input | 1 | Arm pulse: make the loaded count live |
| flip | input | 1 | Swap host and engine banks |
| eng_take | input | 1 | Engine accepts the offered byte (data-in) |
| eng_byte_out | output | 8 | Byte offered to the engine |
| eng_byte_valid | output | 1 | A counted byte is offered |
| eng_put | input | 1 | Engine delivers a byte (data-out) |
| eng_byte_in | input | 8 | Byte from the engine |
| eng_room | output | 1 | A counted byte can be accepted |
| host_empty | output | 1 | Host bank holds no word |
| host_full | output | 1 | Host bank holds WORDS words |
| alt_empty | output | 1 | Engine bank holds no word |
| done | output | 1 | Armed count fully transferred |

## Verification
Every registered result follows the clock edge that samples its stimulus. The flags change after the edge that takes a host write or read, a flip, or an arm pulse. The next offered byte changes after the edge of an engine transfer, and `done` rises after the edge of the final counted byte. `host_rd_data`, `eng_byte_out`, `eng_byte_valid` and `eng_room` are combinational from that registered state. The bench drives every input just after a falling edge and holds it through one rising edge. It reads results at the next falling edge, so each check sees the state exactly one edge after its stimulus. Offered bytes are read before the take pulse that consumes them.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic [CNT_W-1:0]  remain;
        logic              half;
        logic [BYTE_W-1:0] stage;
        logic              done;
    } eng_st_t;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop,
    output logic [WORD_W-1:0] rdata,
    output logic              empty,
    output logic              full
);
    localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [WORDS-1:0][WORD_W-1:0] mem;
        logic [AW-1:0]                wp;
        logic [AW-1:0]                rp;
        logic [CW-1:0]                cnt;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic do_push, do_pop;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(WORDS));
    assign rdata = st_q.mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp = (st_q.wp == AW'(WORDS - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == AW'(WORDS - 1)) ? '0 : st_q.rp + 1'b1;
        end
        if (do_push && !do_pop) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(st_q.wp)));
endmodule

// File: rtl/pp_engine.sv
module pp_engine
    import pp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_in,
    input  logic              cnt_hi_we,
    input  logic              cnt_lo_we,
    input  logic [BYTE_W-1:0] cnt_byte,
    input  logic              cnt_set,
    input  logic              flip,
    input  logic              bank_empty,
    input  logic              bank_full,
    input  logic [WORD_W-1:0] bank_head,
    input  logic              take,
    input  logic              put,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_valid,
    output logic              room,
    output logic              bank_push,
    output logic [WORD_W-1:0] bank_wdata,
    output logic              bank_pop,
    output logic              done
);
    eng_st_t st_d, st_q;
    logic armed, last, xfer_in, xfer_out;

    assign armed      = (st_q.remain != '0);
    assign last       = (st_q.remain == CNT_W'(1));
    assign byte_valid = dir_in && armed && !bank_empty;
    assign room       = !dir_in && armed && !bank_full;
    assign byte_out   = st_q.half ? bank_head[WORD_W-1:BYTE_W] : bank_head[BYTE_W-1:0];
    assign done       = st_q.done;
    assign xfer_in    = byte_valid && take && !cnt_set && !flip;
    assign xfer_out   = room && put && !cnt_set && !flip;

    always_comb begin
        st_d       = st_q;
        bank_push  = 1'b0;
        bank_pop   = 1'b0;
        bank_wdata = '0;
        if (cnt_hi_we) st_d.hi = cnt_byte;
        if (cnt_lo_we) st_d.lo = cnt_byte;
        if (xfer_in) begin
            st_d.remain = st_q.remain - 1'b1;
            if (st_q.half || last) begin
                bank_pop  = 1'b1;
                st_d.half = 1'b0;
            end else begin
                st_d.half = 1'b1;
            end
            if (last) st_d.done = 1'b1;
        end
        if (xfer_out) begin
            st_d.remain = st_q.remain - 1'b1;
            if (st_q.half) begin
                bank_push  = 1'b1;
                bank_wdata = {byte_in, st_q.stage};
                st_d.half  = 1'b0;
            end else if (last) begin
                bank_push  = 1'b1;
                bank_wdata = {{BYTE_W{1'b0}}, byte_in};
            end else begin
                st_d.stage = byte_in;
                st_d.half  = 1'b1;
            end
            if (last) st_d.done = 1'b1;
        end
        if (flip) begin
            st_d.half  = 1'b0;
            st_d.stage = '0;
        end
        if (cnt_set) begin
            st_d.remain = {st_q.hi, st_q.lo};
            st_d.half   = 1'b0;
            st_d.stage  = '0;
            st_d.done   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !cnt_set) |=> st_q.done);
    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_set |=> !st_q.done);
    // R6
    arm_only_on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_set && st_q.remain == '0) |=> (st_q.remain == '0));
    // R7
    count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in && take && byte_valid && !cnt_set && !flip)
        |=> (st_q.remain == $past(st_q.remain) - 1'b1));
endmodule

// File: rtl/pp_xfer_buf.sv
module pp_xfer_buf
    import pp_pkg::*;
#(
    parameter int WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_in,
    input  logic              host_wr_en,
    input  logic [WORD_W-1:0] host_wr_data,
    input  logic              host_rd_en,
    output logic [WORD_W-1:0] host_rd_data,
    input  logic              cnt_hi_we,
    input  logic              cnt_lo_we,
    input  logic [BYTE_W-1:0] cnt_byte,
    input  logic              cnt_set,
    input  logic              flip,
    input  logic              eng_take,
    output logic [BYTE_W-1:0] eng_byte_out,
    output logic              eng_byte_valid,
    input  logic              eng_put,
    input  logic [BYTE_W-1:0] eng_byte_in,
    output logic              eng_room,
    output logic              host_empty,
    output logic              host_full,
    output logic              alt_empty,
    output done
);
    localparam int NBANK = 2;

    logic sel_d, sel_q;
    logic              b_push  [NBANK];
    logic              b_pop   [NBANK];
    logic              b_empty [NBANK];
    logic              b_full  [NBANK];
    logic [WORD_W-1:0] b_wdata [NBANK];
    logic [WORD_W-1:0] b_rdata [NBANK];

    logic              e_push, e_pop;
    logic [WORD_W-1:0] e_wdata;
    logic              eng_sel;

    assign eng_sel = ~sel_q;

    always_comb begin
        sel_d = sel_q;
        if (flip) sel_d = ~sel_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel_d;
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic is_eng;
        assign is_eng     = (eng_sel == 1'(g));
        assign b_push[g]  = is_eng ? e_push  : host_wr_en;
        assign b_pop[g]   = is_eng ? e_pop   : host_rd_en;
        assign b_wdata[g] = is_eng ? e_wdata : host_wr_data;

        pp_bank #(.WORDS(WORDS), .WORD_W(WORD_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (b_push[g]),
            .wdata (b_wdata[g]),
            .pop   (b_pop[g]),
            .rdata (b_rdata[g]),
            .empty (b_empty[g]),
            .full  (b_full[g])
        );
    end

    assign host_rd_data = b_rdata[sel_q];
    assign host_empty   = b_empty[sel_q];
    assign host_full    = b_full[sel_q];
    assign alt_empty    = b_empty[eng_sel];

    pp_engine u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_in     (dir_in),
        .cnt_hi_we  (cnt_hi_we),
        .cnt_lo_we  (cnt_lo_we),
        .cnt_byte   (cnt_byte),
        .cnt_set    (cnt_set),
        .flip       (flip),
        .bank_empty (b_empty[eng_sel]),
        .bank_full  (b_full[eng_sel]),
        .bank_head  (b_rdata[eng_sel]),
        .take       (eng_take),
        .put        (eng_put),
        .byte_in    (eng_byte_in),
        .byte_out   (eng_byte_out),
        .byte_valid (eng_byte_valid),
        .room       (eng_room),
        .bank_push  (e_push),
        .bank_wdata (e_wdata),
        .bank_pop   (e_pop),
        .done       (done)
    );

    // R5
    flip_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flip |=> (sel_q != $past(sel_q)));
    // R12
    idle_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_byte_valid || eng_room) |-> !(eng_byte_valid && eng_room));
endmodule

// File: tb/tb_pp_xfer_buf.sv
module tb_pp_xfer_buf;
    localparam int WORDS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_in = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [15:0] host_wr_data = '0;
    logic        host_rd_en = 1'b0;
    logic [15:0] host_rd_data;
    logic        cnt_hi_we = 1'b0;
    logic        cnt_lo_we = 1'b0;
    logic [7:0]  cnt_byte = '0;
    logic        cnt_set = 1'b0;
    logic        flip = 1'b0;
    logic        eng_take = 1'b0;
    logic [7:0]  eng_byte_out;
    logic        eng_byte_valid;
    logic        eng_put = 1'b0;
    logic [7:0]  eng_byte_in = '0;
    logic        eng_room;
    logic        host_empty, host_full, alt_empty, done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pp_xfer_buf #(.WORDS(WORDS)) dut (
        .clk(clk), .rst_n(rst_n), .dir_in(dir_in),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .cnt_hi_we(cnt_hi_we), .cnt_lo_we(cnt_lo_we), .cnt_byte(cnt_byte),
        .cnt_set(cnt_set), .flip(flip),
        .eng_take(eng_take), .eng_byte_out(eng_byte_out), .eng_byte_valid(eng_byte_valid),
        .eng_put(eng_put), .eng_byte_in(eng_byte_in), .eng_room(eng_room),
        .host_empty(host_empty), .host_full(host_full), .alt_empty(alt_empty), .done(done)
    );

    typedef struct packed {
        logic [15:0] n;
        logic [15:0] w0;
        logic [15:0] w1;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{n: 16'd4, w0: 16'h1234, w1: 16'h5678},
        '{n: 16'd3, w0: 16'hA55A, w1: 16'hC3FF},
        '{n: 16'd1, w0: 16'h99EE, w1: 16'h0000},
        '{n: 16'd2, w0: 16'h0F1E, w1: 16'h0000}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_write(input logic [15:0] w);
        host_wr_en = 1'b1; host_wr_data = w;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_read(output logic [15:0] w);
        w = host_rd_data;
        host_rd_en = 1'b1;
        @(negedge clk);
        host_rd_en = 1'b0;
    endtask

    task automatic do_flip();
        flip = 1'b1;
        @(negedge clk);
        flip = 1'b0;
    endtask

    task automatic load_count(input logic [15:0] n);
        cnt_hi_we = 1'b1; cnt_byte = n[15:8];
        @(negedge clk);
        cnt_hi_we = 1'b0; cnt_lo_we = 1'b1; cnt_byte = n[7:0];
        @(negedge clk);
        cnt_lo_we = 1'b0;
    endtask

    task automatic arm_pulse();
        cnt_set = 1'b1;
        @(negedge clk);
        cnt_set = 1'b0;
    endtask

    task automatic take_byte(output logic [7:0] b, output logic v);
        b = eng_byte_out; v = eng_byte_valid;
        eng_take = 1'b1;
        @(negedge clk);
        eng_take = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        eng_put = 1'b1; eng_byte_in = b;
        @(negedge clk);
        eng_put = 1'b0;
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic [7:0]  b;
        logic        v;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 host_empty", 16'(host_empty), 16'd1);
        chk("R1 alt_empty", 16'(alt_empty), 16'd1);
        chk("R1 host_full", 16'(host_full), 16'd0);
        chk("R1 done", 16'(done), 16'd0);
        chk("R1 no byte offered", 16'(eng_byte_valid), 16'd0);

        // Vector table: data-in chunks, R3 byte order, R9 odd drop, R7/R8
        dir_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            host_write(VECS[i].w0);
            if (VECS[i].n > 16'd2) host_write(VECS[i].w1);
            do_flip();
            chk("R5 engine bank holds data", 16'(alt_empty), 16'd0);
            chk("R5 host bank empty", 16'(host_empty), 16'd1);
            load_count(VECS[i].n);
            arm_pulse();
            chk("R8 arm clears done", 16'(done), 16'd0);
            for (int k = 0; k < int'(VECS[i].n); k++) begin
                logic [15:0] src;
                logic [7:0]  expb;
                src  = (k < 2) ? VECS[i].w0 : VECS[i].w1;
                expb = (k % 2 == 1) ? src[15:8] : src[7:0];
                take_byte(b, v);
                chk("R3 byte valid", 16'(v), 16'd1);
                chk("R3 byte order", 16'(b), 16'(expb));
            end
            chk("R7 stops after count", 16'(eng_byte_valid), 16'd0);
            chk("R8 done after last byte", 16'(done), 16'd1);
            chk("R9 engine bank drained", 16'(alt_empty), 16'd1);
        end

        // R6 count bytes alone do not arm; R12 wait on empty bank; R11
        do_reset();
        dir_in = 1'b1;
        host_write(16'hBEEF);
        do_flip();
        load_count(16'd2);
        chk("R6 not armed before set", 16'(eng_byte_valid), 16'd0);
        repeat (2) @(negedge clk);
        chk("R6 still not armed", 16'(eng_byte_valid), 16'd0);
        arm_pulse();
        chk("R6 armed after set", 16'(eng_byte_valid), 16'd1);
        take_byte(b, v);
        chk("R3 low byte first", 16'(b), 16'h00EF);
        take_byte(b, v);
        chk("R3 high byte second", 16'(b), 16'h00BE);
        chk("R8 done set", 16'(done), 16'd1);
        repeat (3) @(negedge clk);
        chk("R8 done holds", 16'(done), 16'd1);
        host_write(16'h1111);
        host_write(16'h2222);
        arm_pulse();
        chk("R8 set clears done", 16'(done), 16'd0);
        chk("R12 waits on empty bank", 16'(eng_byte_valid), 16'd0);
        host_read(w);
        chk("R11 first word kept", w, 16'h1111);
        host_read(w);
        chk("R11 second word kept", w, 16'h2222);
        chk("R11 host bank drained", 16'(host_empty), 16'd1);

        // R4 / R10 data-out packing with odd count
        do_reset();
        dir_in = 1'b0;
        chk("R7 no room before arm", 16'(eng_room), 16'd0);
        load_count(16'd3);
        arm_pulse();
        chk("R7 room after arm", 16'(eng_room), 16'd1);
        put_byte(8'hA1);
        put_byte(8'hB2);
        put_byte(8'hC3);
        chk("R7 no room after count", 16'(eng_room), 16'd0);
        chk("R8 done data-out", 16'(done), 16'd1);
        do_flip();
        chk("R5 host sees engine data", 16'(host_empty), 16'd0);
        host_read(w);
        chk("R4 packed word", w, 16'hB2A1);
        host_read(w);
        chk("R10 odd tail upper zero", w, 16'h00C3);
        chk("R4 host bank drained", 16'(host_empty), 16'd1);

        // R12 data-out waits on full engine bank
        do_flip();
        load_count(16'(2 * WORDS + 2));
        arm_pulse();
        for (int k = 0; k < 2 * WORDS; k++) put_byte(8'(k));
        chk("R12 no room on full bank", 16'(eng_room), 16'd0);
        chk("R12 done not yet", 16'(done), 16'd0);

        // R2 full flag and ignored write; R5 flags swap
        do_reset();
        for (int k = 0; k <= WORDS; k++) host_write(16'h0100 + 16'(k));
        chk("R2 full", 16'(host_full), 16'd1);
        do_flip();
        chk("R5 host flags swap full", 16'(host_full), 16'd0);
        chk("R5 host flags swap empty", 16'(host_empty), 16'd1);
        chk("R5 alt holds words", 16'(alt_empty), 16'd0);
        do_flip();
        for (int k = 0; k < WORDS; k++) begin
            host_read(w);
            chk("R2 word order", w, 16'h0100 + 16'(k));
        end
        chk("R2 write while full ignored", 16'(host_empty), 16'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule